// File: doc/BRIEF.md
# Serial Peripheral Master with Queued Frames and Select-Line Policies

This block is a serial peripheral interface master for a host that sees it through a small 32-bit register bus. The host writes frames into a transmit queue. A shift engine takes each queued frame, drives the serial clock and data-out line, and samples the data-in line. It places every received frame in a receive queue, unless the host has chosen transmit-only operation. The serial clock rate, the clock polarity and phase, the bit order and the frame length (1 to 8 bits) are all set by registers.

A configurable group of select lines addresses one device at a time. Each line has its own programmable idle level, so a line is driven to the opposite level while it is asserted. Three select policies are provided: assert around every frame, keep the line asserted across frames until the policy or the selected line is rewritten, or never assert. Delays can be programmed for select-to-clock setup, clock-to-select hold, minimum select idle time and the gap between frames. Two watermark conditions, one on each queue, can raise an interrupt. A flash-control register can be written and read back but does not affect operation.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the registers read: divisor (0x00) = 3, clock mode (0x04) = 0, select policy (0x18) = 0, delays (0x28) = 0x0001_0001 and (0x2C) = 0x0000_0001, format (0x40) = 0x0008_0000, idle-level register (0x14) = all implemented lines set, transmit data (0x48) = 0, and receive data (0x4C) = 0x8000_0000.
- R2: While a frame is being shifted, the serial clock period is 2*(div+1) core clock cycles. Between frames, the serial clock rests at the polarity bit, which is bit 1 of register 0x04.
- R3: Bits 19:16 of the format register set the frame length; a value of 0 or above 8 means 8. Bit 2 set sends and assembles the frame least significant bit first; clear means most significant bit first. Received frames are right-aligned.
- R4: With bit 0 of 0x04 (phase) clear, data is sampled on the leading clock edge and changed on the trailing edge; with it set, the roles of the two edges are swapped. A looped-back inverted data-in line returns the inverse of each sent frame for all four clock modes.
- R5: Reading 0x48 returns bit 31 set exactly when the transmit queue (8 entries) is full. A write to 0x48 while the queue is full is discarded.
- R6: Reading 0x4C removes one received frame and returns it in bits 7:0. When the receive queue is empty, the read returns bit 31 set.
- R7: With format bit 3 set, frames are sent but nothing is placed in the receive queue.
- R8: With policy 0 (auto), the line chosen by register 0x10 is asserted for each frame and released after each frame. No other line moves.
- R9: With policy 2 (hold), the chosen line stays asserted between frames until register 0x18 or 0x10 is written.
- R10: With policy 3 (off), no select line is ever asserted, and frames are still shifted out.
- R11: Only implemented lines of 0x14 are writable. Writing all ones reads back as (1<<CS_LINES)-1, and each line idles at its bit.
- R12: Pending register 0x74 has bit 0 set when the transmit count is below the mark in 0x50, and bit 1 set when the receive count exceeds the mark in 0x54. The interrupt output is the OR of pending bits ANDed with the enable register 0x70.
- R13: Register 0x60 reads back what was written and has no effect on frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Watermark interrupt |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | CS_LINES | Select lines, idle at their programmed levels |

## Verification
A bus write to the transmit queue and the engine's removal of the head entry can land on the same clock edge. The same holds for a receive-data read racing a push of a completed frame. The bench provokes the transmit case by writing ten frames on consecutive cycles into an empty queue: the second write meets the engine taking the first entry, so nine frames are accepted, the full flag is seen, and the tenth write is lost. A serial-side monitor rebuilds every frame from the data-out line. It compares each frame against a queue of expected frames, so an extra or missing frame shows up as a miscompare.

// File: rtl/sfm_pkg.sv
`timescale 1ns/1ps
package sfm_pkg;
  typedef enum logic [1:0] {
    CSM_AUTO = 2'd0,
    CSM_RSVD = 2'd1,
    CSM_HOLD = 2'd2,
    CSM_OFF  = 2'd3
  } cs_policy_e;

  typedef enum logic [2:0] {
    E_IDLE, E_SETUP, E_SHIFT, E_HOLD, E_INACT, E_GAP
  } eng_state_e;

  localparam logic [7:0] A_DIV    = 8'h00;
  localparam logic [7:0] A_MODE   = 8'h04;
  localparam logic [7:0] A_CSID   = 8'h10;
  localparam logic [7:0] A_CSDEF  = 8'h14;
  localparam logic [7:0] A_CSMODE = 8'h18;
  localparam logic [7:0] A_DLY0   = 8'h28;
  localparam logic [7:0] A_DLY1   = 8'h2C;
  localparam logic [7:0] A_FMT    = 8'h40;
  localparam logic [7:0] A_TXD    = 8'h48;
  localparam logic [7:0] A_RXD    = 8'h4C;
  localparam logic [7:0] A_TXMK   = 8'h50;
  localparam logic [7:0] A_RXMK   = 8'h54;
  localparam logic [7:0] A_FCTL   = 8'h60;
  localparam logic [7:0] A_IE     = 8'h70;
  localparam logic [7:0] A_IP     = 8'h74;
endpackage

// File: rtl/sfm_fifo.sv
`timescale 1ns/1ps
module sfm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] count_q, count_d;
  logic          do_push, do_pop;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = empty_o ? '0 : mem_q[rp_q];
  assign count_o = count_q;

  always_comb begin
    wp_d    = wp_q;
    rp_d    = rp_q;
    count_d = count_q;
    if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_q <= '0;
    end else begin
      wp_q    <= wp_d;
      rp_q    <= rp_d;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  // R5: a push into a full queue without a pop leaves the count unchanged
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> (count_q == $past(count_q)));

  // R6: a pop from an empty queue leaves it empty
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i) |=> (count_q == '0));
endmodule

// File: rtl/sfm_engine.sv
`timescale 1ns/1ps
module sfm_engine import sfm_pkg::*; #(
  parameter int DIV_W     = 12,
  parameter int DLY_W     = 8,
  parameter int FRAME_MAX = 8,
  localparam int LEN_W    = $clog2(FRAME_MAX + 1),
  localparam int BIT_W    = $clog2(FRAME_MAX),
  localparam int EDGE_W   = LEN_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     div_i,
  input  logic                 cpha_i,
  input  logic                 cpol_i,
  input  cs_policy_e           csmode_i,
  input  logic                 cs_release_i,
  input  logic [DLY_W-1:0]     cssck_i,
  input  logic [DLY_W-1:0]     sckcs_i,
  input  logic [DLY_W-1:0]     intercs_i,
  input  logic [DLY_W-1:0]     interxfr_i,
  input  logic                 lsb_first_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic                 tx_only_i,
  input  logic                 tx_empty_i,
  input  logic [FRAME_MAX-1:0] tx_data_i,
  output logic                 tx_pop_o,
  output logic                 rx_push_o,
  output logic [FRAME_MAX-1:0] rx_data_o,
  output logic                 sck_o,
  output logic                 mosi_o,
  input  logic                 miso_i,
  output logic                 cs_active_o
);
  eng_state_e           st_q, st_d;
  logic [DLY_W-1:0]     dly_q, dly_d;
  logic [DIV_W-1:0]     hcnt_q, hcnt_d;
  logic [EDGE_W-1:0]    edge_q, edge_d;
  logic [LEN_W-1:0]     kout_q, kout_d;
  logic [FRAME_MAX-1:0] tx_q, tx_d, rx_q, rx_d;
  logic                 sck_q, sck_d, cs_q, cs_d, rel_q, rel_d;
  logic                 tick, lead, last_edge;

  function automatic logic [BIT_W-1:0] bitpos(input logic [LEN_W-1:0] k);
    logic [LEN_W-1:0] p;
    p = lsb_first_i ? k : (len_i - 1'b1 - k);
    return p[BIT_W-1:0];
  endfunction

  assign tick      = (hcnt_q == div_i);
  assign lead      = ~edge_q[0];
  assign last_edge = (edge_q == ({len_i, 1'b0} - 1'b1));

  always_comb begin
    st_d = st_q; dly_d = dly_q; hcnt_d = hcnt_q; edge_d = edge_q;
    kout_d = kout_q; tx_d = tx_q; rx_d = rx_q; sck_d = sck_q;
    cs_d = cs_q; rel_d = rel_q | cs_release_i;
    tx_pop_o = 1'b0; rx_push_o = 1'b0;
    case (st_q)
      E_IDLE: begin
        if (rel_d && cs_q) begin
          cs_d = 1'b0; rel_d = 1'b0; dly_d = intercs_i; st_d = E_INACT;
        end else begin
          rel_d = 1'b0;
          if (!tx_empty_i) begin
            tx_pop_o = 1'b1;
            tx_d = tx_data_i; rx_d = '0;
            kout_d = '0; edge_d = '0; hcnt_d = '0;
            if (csmode_i == CSM_OFF || cs_q) st_d = E_SHIFT;
            else begin
              cs_d = 1'b1; dly_d = cssck_i; st_d = E_SETUP;
            end
          end
        end
      end
      E_SETUP: begin
        if (dly_q == '0) st_d = E_SHIFT;
        else dly_d = dly_q - 1'b1;
      end
      E_SHIFT: begin
        if (tick) begin
          hcnt_d = '0;
          sck_d  = ~sck_q;
          if (lead ^ cpha_i) rx_d[bitpos(edge_q[EDGE_W-1:1])] = miso_i;
          else if (!(lead && edge_q == '0)) kout_d = kout_q + 1'b1;
          if (last_edge) begin
            rx_push_o = !tx_only_i;
            if ((csmode_i == CSM_AUTO || csmode_i == CSM_RSVD) && cs_q) begin
              dly_d = sckcs_i; st_d = E_HOLD;
            end else begin
              dly_d = interxfr_i; st_d = E_GAP;
            end
          end else begin
            edge_d = edge_q + 1'b1;
          end
        end else begin
          hcnt_d = hcnt_q + 1'b1;
        end
      end
      E_HOLD: begin
        if (dly_q == '0) begin
          cs_d = 1'b0; dly_d = intercs_i; st_d = E_INACT;
        end else dly_d = dly_q - 1'b1;
      end
      E_INACT, E_GAP: begin
        if (dly_q == '0) st_d = E_IDLE;
        else dly_d = dly_q - 1'b1;
      end
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= E_IDLE; dly_q <= '0; hcnt_q <= '0; edge_q <= '0;
      kout_q <= '0; tx_q <= '0; rx_q <= '0; sck_q <= 1'b0;
      cs_q <= 1'b0; rel_q <= 1'b0;
    end else begin
      st_q <= st_d; dly_q <= dly_d; hcnt_q <= hcnt_d; edge_q <= edge_d;
      kout_q <= kout_d; tx_q <= tx_d; rx_q <= rx_d; sck_q <= sck_d;
      cs_q <= cs_d; rel_q <= rel_d;
    end
  end

  assign rx_data_o   = rx_d;
  assign sck_o       = sck_q ^ cpol_i;
  assign mosi_o      = (kout_q < len_i) ? tx_q[bitpos(kout_q)] : 1'b0;
  assign cs_active_o = cs_q;

  // R2: between frames the clock rests at the polarity level
  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_IDLE) |-> (sck_o == cpol_i));

  // R10: a select is never raised while the policy is off
  p_cs_never_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> ($past(csmode_i) != CSM_OFF));

  // R8: the select level does not change inside a frame
  p_cs_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_SHIFT) |=> (cs_q == $past(cs_q)));
endmodule

// File: rtl/spi_fifo_master.sv
`timescale 1ns/1ps
module spi_fifo_master import sfm_pkg::*; #(
  parameter int CS_LINES  = 4,
  parameter int DEPTH     = 8,
  parameter int DIV_W     = 12,
  parameter int DLY_W     = 8,
  parameter int FRAME_MAX = 8,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int LEN_W    = $clog2(FRAME_MAX + 1),
  localparam int ID_W     = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                irq_o,
  output logic                sck_o,
  output logic                mosi_o,
  input  logic                miso_i,
  output logic [CS_LINES-1:0] cs_o
);
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic [DIV_W-1:0]    div_q;
  logic [1:0]          mode_q;
  logic [ID_W-1:0]     csid_q;
  logic [CS_LINES-1:0] csdef_q;
  cs_policy_e          csmode_q;
  logic [DLY_W-1:0]    cssck_q, sckcs_q, intercs_q, interxfr_q;
  logic [1:0]          proto_q;
  logic                lsb_q, dir_q;
  logic [3:0]          len_q;
  logic [CNT_W-1:0]    txmk_q, rxmk_q;
  logic [31:0]         fctl_q;
  logic [1:0]          ie_q, ip;

  logic wr, rd;
  assign wr = bus_sel && bus_we;
  assign rd = bus_sel && !bus_we;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      div_q <= DIV_W'(3); mode_q <= '0; csid_q <= '0; csdef_q <= '1;
      csmode_q <= CSM_AUTO; cssck_q <= DLY_W'(1); sckcs_q <= DLY_W'(1);
      intercs_q <= DLY_W'(1); interxfr_q <= '0; proto_q <= '0;
      lsb_q <= 1'b0; dir_q <= 1'b0; len_q <= 4'd8;
      txmk_q <= '0; rxmk_q <= '0; fctl_q <= '0; ie_q <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_DIV:    div_q    <= bus_wdata[DIV_W-1:0];
        A_MODE:   mode_q   <= bus_wdata[1:0];
        A_CSID:   csid_q   <= bus_wdata[ID_W-1:0];
        A_CSDEF:  csdef_q  <= bus_wdata[CS_LINES-1:0];
        A_CSMODE: csmode_q <= cs_policy_e'(bus_wdata[1:0]);
        A_DLY0: begin
          cssck_q <= bus_wdata[DLY_W-1:0];
          sckcs_q <= bus_wdata[16 +: DLY_W];
        end
        A_DLY1: begin
          intercs_q  <= bus_wdata[DLY_W-1:0];
          interxfr_q <= bus_wdata[16 +: DLY_W];
        end
        A_FMT: begin
          proto_q <= bus_wdata[1:0];
          lsb_q   <= bus_wdata[2];
          dir_q   <= bus_wdata[3];
          len_q   <= bus_wdata[19:16];
        end
        A_TXMK: txmk_q <= bus_wdata[CNT_W-1:0];
        A_RXMK: rxmk_q <= bus_wdata[CNT_W-1:0];
        A_FCTL: fctl_q <= bus_wdata;
        A_IE:   ie_q   <= bus_wdata[1:0];
        default: ;
      endcase
    end
  end

  logic [FRAME_MAX-1:0] tx_dout, rx_dout, rx_din;
  logic [CNT_W-1:0]     tx_cnt, rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty, tx_pop, rx_push;
  logic tx_push, rx_pop, cs_release, cs_act;
  logic [LEN_W-1:0] len_eff;

  assign tx_push    = wr && (bus_addr == A_TXD);
  assign rx_pop     = rd && (bus_addr == A_RXD);
  assign cs_release = wr && (bus_addr == A_CSID || bus_addr == A_CSMODE);
  assign len_eff    = (len_q == '0 || len_q > 4'(FRAME_MAX)) ? LEN_W'(FRAME_MAX)
                                                              : LEN_W'(len_q);

  sfm_fifo #(.W(FRAME_MAX), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_q), .push_i(tx_push), .data_i(bus_wdata[FRAME_MAX-1:0]),
    .pop_i(tx_pop), .data_o(tx_dout), .count_o(tx_cnt),
    .full_o(tx_full), .empty_o(tx_empty));

  sfm_fifo #(.W(FRAME_MAX), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_q), .push_i(rx_push), .data_i(rx_din),
    .pop_i(rx_pop), .data_o(rx_dout), .count_o(rx_cnt),
    .full_o(rx_full), .empty_o(rx_empty));

  sfm_engine #(.DIV_W(DIV_W), .DLY_W(DLY_W), .FRAME_MAX(FRAME_MAX)) u_eng (
    .clk(clk), .rst_n(rst_q), .div_i(div_q), .cpha_i(mode_q[0]), .cpol_i(mode_q[1]),
    .csmode_i(csmode_q), .cs_release_i(cs_release),
    .cssck_i(cssck_q), .sckcs_i(sckcs_q), .intercs_i(intercs_q), .interxfr_i(interxfr_q),
    .lsb_first_i(lsb_q), .len_i(len_eff), .tx_only_i(dir_q),
    .tx_empty_i(tx_empty), .tx_data_i(tx_dout), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_data_o(rx_din),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_active_o(cs_act));

  for (genvar i = 0; i < CS_LINES; i++) begin : g_cs
    assign cs_o[i] = (cs_act && csid_q == ID_W'(i)) ? ~csdef_q[i] : csdef_q[i];
  end

  assign ip[0] = (tx_cnt < txmk_q);
  assign ip[1] = (rx_cnt > rxmk_q);
  assign irq_o = |(ip & ie_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DIV:    bus_rdata[DIV_W-1:0]    = div_q;
      A_MODE:   bus_rdata[1:0]          = mode_q;
      A_CSID:   bus_rdata[ID_W-1:0]     = csid_q;
      A_CSDEF:  bus_rdata[CS_LINES-1:0] = csdef_q;
      A_CSMODE: bus_rdata[1:0]          = csmode_q;
      A_DLY0:   bus_rdata = {8'h0, DLY_W'(sckcs_q), 8'h0, DLY_W'(cssck_q)};
      A_DLY1:   bus_rdata = {8'h0, DLY_W'(interxfr_q), 8'h0, DLY_W'(intercs_q)};
      A_FMT:    bus_rdata = {12'h0, len_q, 12'h0, dir_q, lsb_q, proto_q};
      A_TXD:    bus_rdata[31] = tx_full;
      A_RXD:    bus_rdata = {rx_empty, 23'h0, rx_dout};
      A_TXMK:   bus_rdata[CNT_W-1:0] = txmk_q;
      A_RXMK:   bus_rdata[CNT_W-1:0] = rxmk_q;
      A_FCTL:   bus_rdata = fctl_q;
      A_IE:     bus_rdata[1:0] = ie_q;
      A_IP:     bus_rdata[1:0] = ip;
      default:  bus_rdata = '0;
    endcase
  end

  // R12: the interrupt output never rises with every enable cleared
  p_irq_enabled_r12: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(irq_o) |-> (ie_q != 2'b00));
endmodule

// File: tb/test_spi_fifo_master.sv
`timescale 1ns/1ps
module test_spi_fifo_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_o, sck_o, mosi_o, miso_i;
  logic [3:0] cs_o;

  always #4 clk = ~clk;
  assign miso_i = ~mosi_o;

  spi_fifo_master i_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_o(cs_o));

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] exp_q[$];
  logic mon_en = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0;
  int m_len = 8, m_csid = 0, m_csmode = 0;
  int f0 = 0, f2 = 0;
  realtime t_last = 0, t_prev = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  always @(negedge cs_o[0]) f0++;
  always @(negedge cs_o[2]) f2++;
  always @(posedge sck_o) begin t_prev = t_last; t_last = $realtime; end

  // monitor: rebuilds frames from the data-out line and compares to the scoreboard
  logic [7:0] acc = '0;
  int nb = 0;
  logic cs_ok = 1'b1;
  always @(sck_o) begin
    if (mon_en && ((sck_o != m_cpol) ^ m_cpha)) begin
      acc = {acc[6:0], mosi_o};
      if (m_csmode != 3 && cs_o[m_csid] !== 1'b0) cs_ok = 1'b0;
      nb++;
      if (nb == m_len) begin
        if (exp_q.size() == 0) check("R4 unexpected frame", {24'h0, acc}, 32'h0);
        else check("R3/R4 frame on data-out", {24'h0, acc}, {24'h0, exp_q.pop_front()});
        check("R8 select asserted during frame", {31'h0, cs_ok}, 32'h1);
        cs_ok = 1'b1; acc = '0; nb = 0;
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_sel = 1'b0;
  endtask

  function automatic logic [7:0] lmask();
    return 8'((16'h1 << m_len) - 1);
  endfunction

  task automatic send(input logic [7:0] d);
    logic [7:0] s;
    s = '0;
    if (m_lsb) for (int i = 0; i < m_len; i++) s[m_len-1-i] = d[i];
    else s = d & lmask();
    exp_q.push_back(s);
    wr(8'h48, {24'h0, d});
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (exp_q.size() != 0 && guard < 20000) begin @(negedge clk); guard++; end
    repeat (40) @(negedge clk);
  endtask

  task automatic rx_expect(input string req, input logic [7:0] d);
    logic [31:0] r;
    rd(8'h4C, r);
    check(req, r, {24'h0, ~d & lmask()});
  endtask

  task automatic set_mode(input logic [1:0] m);
    mon_en = 1'b0;
    wr(8'h04, {30'h0, m});
    m_cpha = m[0]; m_cpol = m[1];
    repeat (3) @(negedge clk);
    mon_en = 1'b1;
  endtask

  initial begin
    logic [31:0] r;
    int a0, a2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(8'h00, r); check("R1 divisor reset", r, 32'h3);
    rd(8'h04, r); check("R1 clock mode reset", r, 32'h0);
    rd(8'h18, r); check("R1 policy reset", r, 32'h0);
    rd(8'h28, r); check("R1 delay0 reset", r, 32'h0001_0001);
    rd(8'h2C, r); check("R1 delay1 reset", r, 32'h0000_0001);
    rd(8'h40, r); check("R1 format reset", r, 32'h0008_0000);
    rd(8'h14, r); check("R1 idle levels reset", r, 32'hF);
    rd(8'h48, r); check("R1 tx data reset", r, 32'h0);
    rd(8'h4C, r); check("R6 empty receive read", r, 32'h8000_0000);

    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, r); check("R11 line count probe", r, 32'hF);
    wr(8'h14, 32'h0000_000B); rd(8'h14, r); check("R11 partial write", r, 32'hB);
    check("R11 idle levels on lines", {28'h0, cs_o}, 32'hB);
    wr(8'h14, 32'hF);

    wr(8'h60, 32'h0000_0001); rd(8'h60, r); check("R13 flash control readback", r, 32'h1);

    wr(8'h70, 32'h3); wr(8'h50, 32'h1);
    rd(8'h74, r); check("R12 tx watermark pending", r, 32'h1);
    check("R12 irq raised", {31'h0, irq_o}, 32'h1);
    wr(8'h50, 32'h0);
    rd(8'h74, r); check("R12 nothing pending", r, 32'h0);

    wr(8'h00, 32'h0);
    for (int m = 0; m < 4; m++) begin
      set_mode(2'(m));
      send(8'hA5 ^ 8'(m * 17)); send(8'h3C);
      drain();
      check("R2 idle clock level", {31'h0, sck_o}, {31'h0, m_cpol});
      rx_expect("R4 loopback first", 8'hA5 ^ 8'(m * 17));
      rx_expect("R4 loopback second", 8'h3C);
    end
    set_mode(2'b00);

    send(8'h96); drain();
    rd(8'h74, r); check("R12 rx watermark pending", r, 32'h2);
    check("R12 irq from rx", {31'h0, irq_o}, 32'h1);
    rx_expect("R6 pop returns frame", 8'h96);
    rd(8'h74, r); check("R12 cleared after pop", r, 32'h0);

    wr(8'h40, 32'h0005_0004); m_len = 5; m_lsb = 1'b1;
    send(8'h16); drain();
    rx_expect("R3 lsb first length 5", 8'h16);
    wr(8'h40, 32'h0005_0000); m_lsb = 1'b0;
    send(8'h1B); drain();
    rx_expect("R3 msb first length 5", 8'h1B);
    wr(8'h40, 32'h0008_0000); m_len = 8;

    wr(8'h00, 32'h2);
    send(8'h5A); drain();
    check("R2 clock period", 32'(int'((t_last - t_prev) * 1000)), 32'd48000);
    rx_expect("R2 frame at slower rate", 8'h5A);
    wr(8'h00, 32'h0);

    a0 = f0;
    send(8'h11); send(8'h22); drain();
    check("R8 select pulses per frame", 32'(f0 - a0), 32'd2);
    check("R8 released after frame", {31'h0, cs_o[0]}, 32'h1);
    rx_expect("R8 data", 8'h11); rx_expect("R8 data", 8'h22);

    wr(8'h18, 32'h2); m_csmode = 2; a0 = f0;
    send(8'h33); send(8'h44); drain();
    check("R9 single select for two frames", 32'(f0 - a0), 32'd1);
    check("R9 still asserted", {31'h0, cs_o[0]}, 32'h0);
    wr(8'h18, 32'h0); m_csmode = 0;
    repeat (6) @(negedge clk);
    check("R9 released on policy write", {31'h0, cs_o[0]}, 32'h1);
    rx_expect("R9 data", 8'h33); rx_expect("R9 data", 8'h44);

    wr(8'h18, 32'h3); m_csmode = 3; a0 = f0;
    send(8'h55); drain();
    check("R10 no select in off policy", 32'(f0 - a0), 32'd0);
    rx_expect("R10 frame still shifted", 8'h55);
    wr(8'h18, 32'h0); m_csmode = 0;

    wr(8'h10, 32'h2); m_csid = 2; a0 = f0; a2 = f2;
    send(8'h66); drain();
    check("R8 chosen line asserted", 32'(f2 - a2), 32'd1);
    check("R8 other line untouched", 32'(f0 - a0), 32'd0);
    rx_expect("R8 data on line 2", 8'h66);
    wr(8'h10, 32'h0); m_csid = 0;

    wr(8'h40, 32'h0008_0008);
    for (int i = 0; i < 10; i++) begin
      if (i < 9) send(8'h40 + 8'(i));
      else wr(8'h48, 32'h0000_00FF);
    end
    rd(8'h48, r); check("R5 full flag", r, 32'h8000_0000);
    drain();
    rd(8'h48, r); check("R5 not full after drain", r, 32'h0);
    rd(8'h4C, r); check("R7 transmit-only leaves rx empty", r, 32'h8000_0000);
    check("R5 dropped write never sent", 32'(exp_q.size()), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule